// File: doc/BRIEF.md
# Fractional Phase-Accumulator Clock Divider

This block divides a reference clock by a programmable fraction N/2^K. A K-bit phase accumulator adds the increment N once per enabled reference cycle. Each time the sum overflows past the top bit, the block requests one output clock edge. After an overflow the accumulator keeps the wrapped remainder; it does not clear. Over any 2^K enabled cycles the block therefore issues exactly N edges, and the pattern repeats with that period.

The remainder also places each edge. When the remainder after an overflow is at least half the increment, the ideal edge time lies nearer the next falling reference edge. In that case the block raises a phase flag so that a downstream output register clocked on both edges emits the edge half a reference cycle late. The rounding error of the edge position drops from one reference period to half a period. Both outputs are registered, so they appear one reference cycle after the addition that produced them.

Top module: `fracdiv_top`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the accumulator clears to zero. After that edge, `edge_req` and `fall_sel` are 0. The first enabled cycle after reset adds the increment to zero.
- R2: On each rising edge with `en` high, the accumulator adds `incr`. `edge_req` is 1 in the cycle after an addition whose sum reaches 2^ACC_W, and 0 otherwise.
- R3: On overflow the accumulator keeps the low ACC_W bits of the sum. As a result, exactly `incr` edges are requested in every 2^ACC_W enabled cycles started from a cleared accumulator.
- R4: `fall_sel` is 1 only together with `edge_req`. It is 1 exactly when twice the kept remainder is greater than or equal to `incr`. `fall_sel` = 1 means the falling reference edge; 0 means the rising edge.
- R5: An increment of 0 never requests an edge.
- R6: While `en` is low, the accumulator holds its value, and both outputs are 0 in the following cycle. Accumulation resumes from the held value.
- R7: With ACC_W = 3 and `incr` = 3 after reset, edges are requested after the 3rd, 6th and 8th enabled additions. Only the one after the 6th addition (remainder 2) has `fall_sel` = 1.
- R8: The sequence of (`edge_req`, `fall_sel`) pairs repeats with a period of 2^ACC_W enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Accumulate enable |
| incr | input | ACC_W | Fractional increment N (ratio N/2^ACC_W) |
| edge_req | output | 1 | One-cycle request for an output clock edge |
| fall_sel | output | 1 | Phase select for the requested edge: 1 = falling, 0 = rising |

## Verification
Every result is due one reference cycle after the rising edge that performs the addition, because the outputs come from a single register stage after the combinational adder. The bench changes inputs and samples outputs 1 ns after a rising edge. Each sample therefore reflects exactly the addition made at that edge. The bench counts enabled edges from the moment reset is released, so the n-th sample corresponds to the n-th addition. For freeze and reset cases, the output is sampled in the cycle right after the disabling edge, and the resumed sequence is then checked for the carry that the held value predicts.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
   // Largest accumulator width accepted by the divider
   localparam int FRACDIV_MAX_W = 16;

   // Phase selection encoding for a requested edge
   typedef enum logic {
      PHASE_RISE = 1'b0,
      PHASE_FALL = 1'b1
   } phase_e;
endpackage

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [W-1:0] incr,
   output logic         carry,
   output logic [W-1:0] leftover
);
   localparam int SUM_W = W + 1;

   logic [W-1:0]     acc;
   logic [SUM_W-1:0] sum;

   assign sum      = {1'b0, acc} + {1'b0, incr};
   assign carry    = sum[W];
   assign leftover = sum[W-1:0];

   always_ff @(posedge clk) begin
      if (rst)     acc <= '0;
      else if (en) acc <= leftover;
   end

   // R6
   frozen_acc_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc));

   // R3
   keep_rem_chk: assert property (@(posedge clk) disable iff (rst)
      (en && carry) |=> (acc < $past(incr)));
endmodule

// File: rtl/fracdiv_phase.sv
module fracdiv_phase #(
   parameter int W = 3
) (
   input  logic [W-1:0] incr,
   input  logic [W-1:0] leftover,
   output fracdiv_pkg::phase_e phase
);
   import fracdiv_pkg::*;

   localparam int CMP_W = W + 1;

   logic [CMP_W-1:0] twice_rem;
   logic [CMP_W-1:0] incr_ext;

   assign twice_rem = {leftover, 1'b0};
   assign incr_ext  = {1'b0, incr};

   always_comb begin
      phase = PHASE_RISE;
      if (twice_rem >= incr_ext) phase = PHASE_FALL;
   end
endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top #(
   parameter int ACC_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [ACC_W-1:0] incr,
   output logic             edge_req,
   output logic             fall_sel
);
   import fracdiv_pkg::*;

   generate
      if (ACC_W < 1 || ACC_W > FRACDIV_MAX_W) begin : g_bad_width
         $error("fracdiv_top: ACC_W out of range");
      end
   endgenerate

   logic             carry;
   logic [ACC_W-1:0] leftover;
   phase_e           phase;

   fracdiv_accum #(.W(ACC_W)) u_accum (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .incr     (incr),
      .carry    (carry),
      .leftover (leftover)
   );

   fracdiv_phase #(.W(ACC_W)) u_phase (
      .incr     (incr),
      .leftover (leftover),
      .phase    (phase)
   );

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         edge_req <= 1'b0;
         fall_sel <= 1'b0;
      end else begin
         edge_req <= carry;
         fall_sel <= carry && (phase == PHASE_FALL);
      end
   end

   // R1
   reset_out_chk: assert property (@(posedge clk)
      rst |=> (!edge_req && !fall_sel));

   // R4
   fall_with_edge_chk: assert property (@(posedge clk) disable iff (rst)
      fall_sel |-> edge_req);

   // R6
   idle_out_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> !edge_req);

   // R5
   zero_incr_chk: assert property (@(posedge clk) disable iff (rst)
      (incr == '0) |=> !edge_req);

   // R2
   edge_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      edge_req |-> $past(en));
endmodule

// File: tb/fracdiv_top_test.sv
module fracdiv_top_test;
   localparam int K      = 3;
   localparam int PERIOD = 1 << K;
   localparam int NVEC   = 8;

   // incr, expected edges per period, expected falling-phase edges
   localparam logic [11:0] VEC [NVEC] = '{
      {4'd0, 4'd0, 4'd0},
      {4'd1, 4'd1, 4'd0},
      {4'd2, 4'd2, 4'd0},
      {4'd3, 4'd3, 4'd1},
      {4'd4, 4'd4, 4'd0},
      {4'd5, 4'd5, 4'd2},
      {4'd6, 4'd6, 4'd2},
      {4'd7, 4'd7, 4'd3}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         en  = 1'b0;
   logic [K-1:0] incr = '0;
   logic         edge_req, fall_sel;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   int m_acc;

   always #5 clk = ~clk;

   fracdiv_top #(.ACC_W(K)) uut (
      .clk(clk), .rst(rst), .en(en), .incr(incr),
      .edge_req(edge_req), .fall_sel(fall_sel)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic start(input int v);
      rst  = 1'b1;
      en   = 1'b1;
      incr = K'(v);
      @(posedge clk); #1;
      rst   = 1'b0;
      m_acc = 0;
   endtask

   task automatic step(output bit e, output bit f);
      @(posedge clk); #1;
      e = edge_req;
      f = fall_sel;
   endtask

   // one period: count edges/falls and compare each cycle with the model
   task automatic window(input int v, output int ne, output int nf, output int bad);
      bit e, f, me, mf;
      int s;
      ne = 0; nf = 0; bad = 0;
      for (int c = 0; c < PERIOD; c++) begin
         step(e, f);
         s     = m_acc + v;
         me    = (s >= PERIOD);
         m_acc = s % PERIOD;
         mf    = me && (2 * m_acc >= v);
         if (e) ne++;
         if (f) nf++;
         if (e != me || f != mf) bad++;
      end
   endtask

   initial begin
      bit e, f;
      int ne, nf, bad, ne2, nf2, bad2;
      // R1: reset state
      repeat (2) @(posedge clk);
      #1;
      check("R1 edge_req in reset", edge_req, 0);
      check("R1 fall_sel in reset", fall_sel, 0);

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         int v, xe, xf;
         v  = int'(VEC[i][11:8]);
         xe = int'(VEC[i][7:4]);
         xf = int'(VEC[i][3:0]);
         start(v);
         window(v, ne, nf, bad);
         check("R3 edges per period", ne, xe);
         check("R4 falling edges per period", nf, xf);
         check("R2 per-cycle model mismatches", bad, 0);
         window(v, ne2, nf2, bad2);
         check("R8 repeat edges", ne2, ne);
         check("R8 repeat falls", nf2, nf);
         if (v == 0) check("R5 zero increment edges", ne + ne2, 0);
      end

      // R7: cycle-exact 3/8 pattern
      start(3);
      for (int c = 1; c <= PERIOD; c++) begin
         step(e, f);
         check($sformatf("R7 edge after add %0d", c), e,
               (c == 3 || c == 6 || c == 8) ? 1 : 0);
         check($sformatf("R7 phase after add %0d", c), f, (c == 6) ? 1 : 0);
      end

      // R6: freeze with acc at 6, then resume
      start(3);
      step(e, f); step(e, f);        // acc = 6
      en = 1'b0;
      for (int c = 0; c < 4; c++) begin
         step(e, f);
         check("R6 edge_req low while disabled", e, 0);
         check("R6 fall_sel low while disabled", f, 0);
      end
      en = 1'b1;
      step(e, f);                    // 6+3 = 9 -> carry, remainder 1
      check("R6 resume edge from held value", e, 1);
      check("R6 resume phase rising", f, 0);
      step(e, f);                    // 1+3 = 4 -> no carry
      check("R6 resume no edge", e, 0);

      // R1: mid-run reset clears accumulator
      start(3);
      step(e, f); step(e, f);        // acc = 6
      rst = 1'b1;
      step(e, f);
      check("R1 edge_req after mid-run reset", e, 0);
      rst = 1'b0;
      step(e, f);                    // 0+3
      check("R1 no edge on 1st add", e, 0);
      step(e, f);                    // 6
      check("R1 no edge on 2nd add", e, 0);
      step(e, f);                    // 9 -> carry
      check("R1 edge on 3rd add", e, 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule